// File: doc/BRIEF.md
# Queued Command-Driven SPI Master

This block is an SPI master that works through a list of up to sixteen transfers with no processor involvement. Each of the sixteen slots has a command byte, a transmit word and a receive word. Software writes the command and transmit memories, sets a first-slot pointer and a last-slot pointer, and pulses `go`. The block then runs each slot from the first pointer to the last one, wrapping from slot 15 back to slot 0. For each slot it drives that slot's chip-select pattern and shifts the transmit word out most significant bit first. At the same time it gathers the word returned by the slave into the matching receive slot.

The serial clock is made from the bus clock by a programmable divider. Clock polarity and phase are selectable. A completed-slot pointer shows how far the queue has progressed. A one-cycle `done` pulse marks the end of the queue, and the chip selects then return to a programmable idle pattern.

Top module: `spi_queue_master`

## Requirements
- R1: The block runs slots from `start_ptr` through `end_ptr` inclusive, stepping upward modulo 16, so a start pointer above the end pointer wraps past slot 15 to slot 0. Receive slots outside that range keep their previous contents.
- R2: While a slot is being transferred, `cs` equals bits 3:0 of that slot's command byte. Whenever no queue is running, `cs` equals `cs_idle`.
- R3: When command bit 7 is clear, the transfer width is 8 bits. When it is set, the width is `width_cfg` limited to the range 8 to 16: values below 8 give 8 and values above 16 give 16. Command bits 6:4 have no effect.
- R4: `mosi` carries the low W bits of the slot's transmit word, most significant of them first, and the bits above W are ignored. A queue run leaves transmit memory unchanged, so a later run sends the same words.
- R5: At the end of a slot, the W bits received are written right-justified into the receive slot of the same index, and the bits above W are cleared. `rx_rdata` shows the slot addressed by `rx_raddr`, and nothing outside the block can write it.
- R6: `sck` rests at `cpol` when idle. With `cpha` = 0, `miso` is sampled on the leading edge and `mosi` changes on the trailing edge. With `cpha` = 1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R7: Each `sck` half period lasts H bus cycles, where H is `baud` (a value of 1 acts as 2). A slot takes 2W+1 half periods: one leading half period at the idle level with the chip selects already driven, then 2W toggling half periods.
- R8: While `baud` is 0, `sck` and the progress of the queue are frozen. Restoring the previous nonzero value resumes the transfer where it stopped.
- R9: `cmpl_ptr` holds the index of the most recently finished slot, changing in the cycle after that slot's last half period.
- R10: `busy` rises in the cycle after `go` is seen while idle. `done` pulses for exactly one cycle, in the first cycle `busy` is low after the last slot. `go` is ignored while `busy` is high.
- R11: After reset, `busy`, `done` and `cmpl_ptr` are 0, `sck` is low, `cs` equals `cs_idle`, and every receive slot reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command memory write strobe |
| cmd_waddr | input | 4 | Command slot to write |
| cmd_wdata | input | 8 | Command byte: bit 7 selects the width source, bits 3:0 are the chip-select pattern |
| tx_we | input | 1 | Transmit memory write strobe |
| tx_waddr | input | 4 | Transmit slot to write |
| tx_wdata | input | 16 | Transmit word, right-justified |
| rx_raddr | input | 4 | Receive slot to read |
| rx_rdata | output | 16 | Receive word of the addressed slot |
| cpol | input | 1 | Idle level of `sck` |
| cpha | input | 1 | Clock phase select |
| baud | input | 8 | Half-period length in bus cycles; 0 freezes the clock |
| width_cfg | input | 5 | Width used by commands with bit 7 set |
| cs_idle | input | 4 | Chip-select pattern when no queue is running |
| start_ptr | input | 4 | First slot of the queue |
| end_ptr | input | 4 | Last slot of the queue |
| go | input | 1 | Start request |
| busy | output | 1 | Queue running |
| done | output | 1 | One-cycle end-of-queue pulse |
| cmpl_ptr | output | 4 | Last finished slot |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 4 | Chip-select levels |

## Verification
The assertions assume that `cpol`, `cpha`, `width_cfg` and the memory contents of the queued slots stay constant while `busy` is high. They also assume that `go` is a synchronous pulse and that `baud` changes during a run only to 0 and then back to its previous value. The stimulus sets every configuration input between queue runs only. Its single mid-run change is the pause: `baud` is forced to 0 and later restored. The one `go` pulse issued while busy comes during that pause, with a different start pointer, so that it would change the slot order if it were honoured.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } spiq_state_e;

  typedef struct packed {
    logic       wide;
    logic [2:0] rsvd;
    logic [3:0] csel;
  } spiq_cmd_t;

endpackage

// File: rtl/spiq_rst_sync.sv
module spiq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/spiq_regfile.sv
module spiq_regfile #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [DEPTH-1:0][W-1:0] ent_flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic         en;
    logic [W-1:0] ent_q;
    assign en = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q <= '0;
      else if (en) ent_q <= wdata;
    end
    assign ent_flat[i] = ent_q;
  end

  assign rdata = ent_flat[raddr];
endmodule

// File: rtl/spiq_clkdiv.sv
module spiq_clkdiv #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] baud,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q, cnt_d;
  logic [DIVW-1:0] half_m1;
  logic            frozen;

  assign half_m1 = ((baud < DIVW'(2)) ? DIVW'(2) : baud) - DIVW'(1);
  assign frozen  = (baud == '0);
  assign tick    = run && !frozen && (cnt_q >= half_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (frozen) cnt_d = cnt_q;
    else if (tick)   cnt_d = '0;
    else             cnt_d = cnt_q + DIVW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spiq_shifter.sv
module spiq_shifter #(
  parameter int MAXW = 16,
  parameter int LW   = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MAXW-1:0] load_word,
  input  logic [LW-1:0]   load_width,
  input  logic            tx_shift,
  input  logic            rx_sample,
  input  logic            miso,
  output logic            mosi,
  output logic [MAXW-1:0] rx_word
);
  logic [MAXW-1:0] txsh_q, txsh_d;
  logic [MAXW-1:0] rxsh_q, rxsh_d;

  always_comb begin
    txsh_d = txsh_q;
    if (load)          txsh_d = load_word << (LW'(MAXW) - load_width);
    else if (tx_shift) txsh_d = txsh_q << 1;
  end

  always_comb begin
    rxsh_d = rxsh_q;
    if (load)           rxsh_d = '0;
    else if (rx_sample) rxsh_d = {rxsh_q[MAXW-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh_q <= '0;
      rxsh_q <= '0;
    end else begin
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
    end
  end

  assign mosi    = txsh_q[MAXW-1];
  assign rx_word = rxsh_q;
endmodule

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
  import spiq_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int MAXW  = 16,
  parameter int WCFGW = 5,
  parameter int PW    = $clog2(NSLOT),
  parameter int LW    = $clog2(MAXW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [PW-1:0]    start_ptr,
  input  logic [PW-1:0]    end_ptr,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [WCFGW-1:0] width_cfg,
  input  logic [3:0]       cs_idle,
  input  logic             tick,
  input  logic [7:0]       slot_cmd,
  output logic [PW-1:0]    slot_addr,
  output logic             load,
  output logic [LW-1:0]    load_width,
  output logic             tx_shift,
  output logic             rx_sample,
  output logic             rx_we,
  output logic [PW-1:0]    rx_waddr,
  output logic             busy,
  output logic             done,
  output logic [PW-1:0]    cmpl_ptr,
  output logic             sck,
  output logic [3:0]       cs
);
  localparam int PHW = $clog2(2 * MAXW + 1);

  spiq_state_e   state_q, state_d;
  logic [PW-1:0] ptr_q, ptr_d, end_q, end_d, cmpl_q, cmpl_d;
  logic [PHW-1:0] ph_q, ph_d;
  logic [LW-1:0] wid_q, wid_d;
  logic [3:0]    csq_q, csq_d;
  logic          sck_q, sck_d, done_q, done_d;

  spiq_cmd_t     cmd;
  logic          unused_rsvd;
  logic          idle, start, fin, adv, last_slot, lead;
  logic [PHW-1:0] ph_last, nxt_ph;

  function automatic logic [LW-1:0] clamp_width(input logic [WCFGW-1:0] v);
    if (int'(v) < 8)         return LW'(8);
    else if (int'(v) > MAXW) return LW'(MAXW);
    else                     return LW'(v);
  endfunction

  assign cmd         = spiq_cmd_t'(slot_cmd);
  assign unused_rsvd = ^cmd.rsvd;

  assign idle      = (state_q == ST_IDLE);
  assign ph_last   = PHW'(wid_q) << 1;
  assign nxt_ph    = ph_q + PHW'(1);
  assign lead      = nxt_ph[0];
  assign start     = idle && go;
  assign fin       = !idle && tick && (ph_q == ph_last);
  assign adv       = !idle && tick && (ph_q != ph_last);
  assign last_slot = (ptr_q == end_q);
  assign load      = start || (fin && !last_slot);
  assign slot_addr = idle ? start_ptr : ptr_q + PW'(1);
  assign load_width = cmd.wide ? clamp_width(width_cfg) : LW'(8);

  // data launch / sample edges per phase mode
  assign tx_shift  = adv && (cpha ? (lead && (nxt_ph != PHW'(1)))
                                  : (!lead && (nxt_ph != ph_last)));
  assign rx_sample = adv && (cpha ? !lead : lead);
  assign rx_we     = fin;
  assign rx_waddr  = ptr_q;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    end_d   = end_q;
    cmpl_d  = cmpl_q;
    ph_d    = ph_q;
    wid_d   = wid_q;
    csq_d   = csq_q;
    sck_d   = sck_q;
    done_d  = 1'b0;
    if (start) begin
      state_d = ST_RUN;
      ptr_d   = start_ptr;
      end_d   = end_ptr;
      ph_d    = '0;
      wid_d   = load_width;
      csq_d   = cmd.csel;
      sck_d   = cpol;
    end else if (fin) begin
      cmpl_d = ptr_q;
      sck_d  = cpol;
      if (last_slot) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end else begin
        ptr_d = ptr_q + PW'(1);
        ph_d  = '0;
        wid_d = load_width;
        csq_d = cmd.csel;
      end
    end else if (adv) begin
      ph_d  = nxt_ph;
      sck_d = !sck_q;
    end else if (idle) begin
      sck_d = cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      end_q   <= '0;
      cmpl_q  <= '0;
      ph_q    <= '0;
      wid_q   <= LW'(8);
      csq_q   <= '0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      end_q   <= end_d;
      cmpl_q  <= cmpl_d;
      ph_q    <= ph_d;
      wid_q   <= wid_d;
      csq_q   <= csq_d;
      sck_q   <= sck_d;
      done_q  <= done_d;
    end
  end

  assign busy     = !idle;
  assign done     = done_q;
  assign cmpl_ptr = cmpl_q;
  assign sck      = sck_q;
  assign cs       = idle ? cs_idle : csq_q;
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master #(
  parameter int NSLOT = 16,
  parameter int MAXW  = 16,
  parameter int DIVW  = 8,
  parameter int WCFGW = 5,
  parameter int PW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [PW-1:0]    cmd_waddr,
  input  logic [7:0]       cmd_wdata,
  input  logic             tx_we,
  input  logic [PW-1:0]    tx_waddr,
  input  logic [MAXW-1:0]  tx_wdata,
  input  logic [PW-1:0]    rx_raddr,
  output logic [MAXW-1:0]  rx_rdata,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIVW-1:0]  baud,
  input  logic [WCFGW-1:0] width_cfg,
  input  logic [3:0]       cs_idle,
  input  logic [PW-1:0]    start_ptr,
  input  logic [PW-1:0]    end_ptr,
  input  logic             go,
  output logic             busy,
  output logic             done,
  output logic [PW-1:0]    cmpl_ptr,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [3:0]       cs
);
  localparam int LW = $clog2(MAXW + 1);

  logic            rst_sn;
  logic [PW-1:0]   slot_addr, rx_waddr;
  logic [7:0]      slot_cmd;
  logic [MAXW-1:0] slot_tx, rx_word;
  logic [LW-1:0]   load_width;
  logic            load, tx_shift, rx_sample, rx_we, tick;

  spiq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  spiq_regfile #(.DEPTH(NSLOT), .W(8)) u_cmd_mem (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (cmd_we),
    .waddr (cmd_waddr),
    .wdata (cmd_wdata),
    .raddr (slot_addr),
    .rdata (slot_cmd)
  );

  spiq_regfile #(.DEPTH(NSLOT), .W(MAXW)) u_tx_mem (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (tx_we),
    .waddr (tx_waddr),
    .wdata (tx_wdata),
    .raddr (slot_addr),
    .rdata (slot_tx)
  );

  spiq_regfile #(.DEPTH(NSLOT), .W(MAXW)) u_rx_mem (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (rx_we),
    .waddr (rx_waddr),
    .wdata (rx_word),
    .raddr (rx_raddr),
    .rdata (rx_rdata)
  );

  spiq_clkdiv #(.DIVW(DIVW)) u_div (
    .clk   (clk),
    .rst_n (rst_sn),
    .run   (busy),
    .baud  (baud),
    .tick  (tick)
  );

  spiq_shifter #(.MAXW(MAXW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sn),
    .load       (load),
    .load_word  (slot_tx),
    .load_width (load_width),
    .tx_shift   (tx_shift),
    .rx_sample  (rx_sample),
    .miso       (miso),
    .mosi       (mosi),
    .rx_word    (rx_word)
  );

  spiq_ctrl #(.NSLOT(NSLOT), .MAXW(MAXW), .WCFGW(WCFGW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sn),
    .go         (go),
    .start_ptr  (start_ptr),
    .end_ptr    (end_ptr),
    .cpol       (cpol),
    .cpha       (cpha),
    .width_cfg  (width_cfg),
    .cs_idle    (cs_idle),
    .tick       (tick),
    .slot_cmd   (slot_cmd),
    .slot_addr  (slot_addr),
    .load       (load),
    .load_width (load_width),
    .tx_shift   (tx_shift),
    .rx_sample  (rx_sample),
    .rx_we      (rx_we),
    .rx_waddr   (rx_waddr),
    .busy       (busy),
    .done       (done),
    .cmpl_ptr   (cmpl_ptr),
    .sck        (sck),
    .cs         (cs)
  );
endmodule

// File: rtl/spiq_chk.sv
module spiq_chk #(
  parameter int DIVW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            go,
  input logic            busy,
  input logic            done,
  input logic            sck,
  input logic            cpol,
  input logic [DIVW-1:0] baud,
  input logic [3:0]      cs
);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);

  a_r10_end_marked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  a_r8_frozen_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && baud == '0) |=> $stable(sck));

  a_r2_cs_steady_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sck != cpol) |=> (busy && $stable(cs)));
endmodule

bind spi_queue_master spiq_chk #(.DIVW(DIVW)) u_chk (
  .clk  (clk),
  .rst_n(rst_sn),
  .go   (go),
  .busy (busy),
  .done (done),
  .sck  (sck),
  .cpol (cpol),
  .baud (baud),
  .cs   (cs)
);

// File: tb/spi_queue_master_tb.sv
`timescale 1ns/1ps
module spi_queue_master_tb;
  logic        clk, rst_n;
  logic        cmd_we, tx_we;
  logic [3:0]  cmd_waddr, tx_waddr, rx_raddr;
  logic [7:0]  cmd_wdata;
  logic [15:0] tx_wdata, rx_rdata;
  logic        cpol, cpha, go, miso;
  logic [7:0]  baud;
  logic [4:0]  width_cfg;
  logic [3:0]  cs_idle, start_ptr, end_ptr, cmpl_ptr, cs;
  logic        busy, done, sck, mosi;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // behavioural reference state
  logic [7:0]  m_cmd [16];
  logic [15:0] m_tx  [16];
  logic [15:0] exp_rx[16];
  logic [15:0] m_pat;
  int m_busy, m_done, m_ent, m_end, m_n, m_h, m_w, m_cmpl, rc;

  spi_queue_master u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we), .cmd_waddr(cmd_waddr), .cmd_wdata(cmd_wdata),
    .tx_we(tx_we), .tx_waddr(tx_waddr), .tx_wdata(tx_wdata),
    .rx_raddr(rx_raddr), .rx_rdata(rx_rdata),
    .cpol(cpol), .cpha(cpha), .baud(baud), .width_cfg(width_cfg),
    .cs_idle(cs_idle), .start_ptr(start_ptr), .end_ptr(end_ptr), .go(go),
    .busy(busy), .done(done), .cmpl_ptr(cmpl_ptr),
    .sck(sck), .mosi(mosi), .miso(miso), .cs(cs)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int width_of(input logic [7:0] c, input logic [4:0] wc);
    if (!c[7])   return 8;
    if (wc < 8)  return 8;
    if (wc > 16) return 16;
    return int'(wc);
  endfunction

  function automatic logic [15:0] pat_of(input int e, input int r);
    return 16'hC39A ^ (16'(e) * 16'h1111) ^ (16'(r) * 16'h0F35);
  endfunction

  task automatic begin_slot(input int e);
    m_ent = e;
    m_n   = 0;
    m_w   = width_of(m_cmd[e], width_cfg);
    m_pat = pat_of(e, rc);
  endtask

  task automatic model_update();
    int p, k;
    m_done = 0;
    if (m_busy == 0) begin
      if (go) begin
        m_busy = 1;
        m_end  = int'(end_ptr);
        m_h    = (baud < 2) ? 2 : int'(baud);
        begin_slot(int'(start_ptr));
      end
    end else if (baud != 0) begin
      m_n++;
      if (m_n == (2 * m_w + 1) * m_h) begin
        m_cmpl = m_ent;
        exp_rx[m_ent] = m_pat & 16'((32'd1 << m_w) - 1);
        if (m_ent == m_end) begin
          m_busy = 0;
          m_done = 1;
        end else begin
          begin_slot((m_ent + 1) % 16);
        end
      end
    end
    if (m_busy != 0) begin
      p = m_n / m_h;
      k = cpha ? ((p == 0) ? 0 : (p - 1) / 2) : p / 2;
      if (k > m_w - 1) k = m_w - 1;
      miso = m_pat[m_w - 1 - k];
    end else begin
      miso = 1'b0;
    end
  endtask

  task automatic compare();
    int p, j;
    chk("R10", "busy", busy, m_busy);
    chk("R10", "done", done, m_done);
    chk("R9", "cmpl_ptr", cmpl_ptr, m_cmpl);
    if (m_busy != 0) begin
      p = m_n / m_h;
      chk("R2", "cs in slot", cs, m_cmd[m_ent][3:0]);
      chk("R7", "sck level", sck, cpol ^ logic'(p % 2));
      j = cpha ? ((p <= 2) ? 0 : (p - 1) / 2) : p / 2;
      if (j > m_w - 1) j = m_w - 1;
      chk("R4", "mosi bit", mosi, m_tx[m_ent][m_w - 1 - j]);
    end else begin
      chk("R2", "cs idle", cs, cs_idle);
      chk("R6", "sck idle", sck, cpol);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #0.5;
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic wr_cmd(input int a, input logic [7:0] d);
    cmd_we = 1'b1; cmd_waddr = 4'(a); cmd_wdata = d; m_cmd[a] = d;
    step();
    cmd_we = 1'b0;
  endtask

  task automatic wr_tx(input int a, input logic [15:0] d);
    tx_we = 1'b1; tx_waddr = 4'(a); tx_wdata = d; m_tx[a] = d;
    step();
    tx_we = 1'b0;
  endtask

  task automatic check_rx(input int s, input int e, input string tag);
    for (int i = 0; i < 16; i++) begin
      bit in_rng;
      in_rng = ((i - s + 16) % 16) <= ((e - s + 16) % 16);
      rx_raddr = 4'(i);
      #0.3;
      if (in_rng) chk(tag, "rx slot in range", rx_rdata, exp_rx[i]);
      else        chk("R1", "rx slot outside range", rx_rdata, exp_rx[i]);
    end
  endtask

  task automatic run_queue(input int s, input int e, input string tag, input bit pause);
    int guard;
    logic [7:0] keep_baud;
    logic       s0;
    rc++;
    start_ptr = 4'(s); end_ptr = 4'(e);
    go = 1'b1;
    step();
    go = 1'b0;
    if (pause) begin
      repeat (25) step();
      keep_baud = baud;
      baud = 8'd0;
      step();
      s0 = sck;
      repeat (12) begin
        step();
        chk("R8", "sck frozen", sck, s0);
      end
      // go with another start slot while busy: must be ignored (R10)
      start_ptr = 4'((s + 5) % 16);
      go = 1'b1;
      step();
      go = 1'b0;
      start_ptr = 4'(s);
      baud = keep_baud;
    end
    guard = 0;
    while (m_busy != 0 && guard < 20000) begin
      step();
      guard++;
    end
    step();
    check_rx(s, e, tag);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_we = 1'b0; tx_we = 1'b0; go = 1'b0; miso = 1'b0;
    cmd_waddr = '0; tx_waddr = '0; rx_raddr = 4'd3; cmd_wdata = '0; tx_wdata = '0;
    cpol = 1'b0; cpha = 1'b0; baud = 8'd2; width_cfg = 5'd12; cs_idle = 4'hF;
    start_ptr = '0; end_ptr = '0;
    m_busy = 0; m_done = 0; m_ent = 0; m_end = 0; m_n = 0; m_h = 2; m_w = 8;
    m_cmpl = 0; rc = 0; m_pat = '0;
    for (int i = 0; i < 16; i++) begin
      m_cmd[i] = '0; m_tx[i] = '0; exp_rx[i] = '0;
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "busy in reset", busy, 1'b0);
    chk("R11", "done in reset", done, 1'b0);
    chk("R11", "sck in reset", sck, 1'b0);
    chk("R11", "cs in reset", cs, 4'hF);
    chk("R11", "cmpl_ptr in reset", cmpl_ptr, 4'h0);
    #0.3;
    chk("R11", "rx slot in reset", rx_rdata, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // slots: every third uses 8 bits (bit7 clear), others take width_cfg with junk in bits 6:4 (R3)
    for (int i = 0; i < 16; i++) begin
      logic [3:0] pat;
      pat = 4'(i) ^ 4'hA;
      wr_cmd(i, (i % 3 == 0) ? {4'b0000, pat} : {4'b1101, pat});
      wr_tx(i, 16'h5A00 ^ (16'(i) * 16'h1357));
    end

    // all four clock modes (R6)
    for (int mode = 0; mode < 4; mode++) begin
      cpol = mode[1];
      cpha = mode[0];
      step();
      run_queue(0, 3, "R6", 1'b0);
    end

    // width limiting (R3)
    cpol = 1'b0; cpha = 1'b1;
    width_cfg = 5'd5;
    step();
    run_queue(4, 5, "R3", 1'b0);
    width_cfg = 5'd20; baud = 8'd3;
    step();
    run_queue(6, 8, "R3", 1'b0);

    // wrap from slot 15 to 0, other idle pattern (R1, R5)
    width_cfg = 5'd16; baud = 8'd2; cs_idle = 4'h0; cpol = 1'b1; cpha = 1'b0;
    step();
    run_queue(14, 1, "R5", 1'b0);

    // pause with baud 0 and go while busy (R8, R10)
    baud = 8'd4; width_cfg = 5'd10;
    step();
    run_queue(9, 10, "R8", 1'b0 | 1'b1);

    // single slot, transmit memory reused unchanged (R4)
    baud = 8'd1;
    step();
    run_queue(2, 2, "R4", 1'b0);
    run_queue(2, 2, "R4", 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule